// File: doc/BRIEF.md
# Grouped Interrupt Control Register Bank

This block holds the control state for eighteen interrupt groups. Each group has four hardware sources. A group's 16-bit register carries a 3-bit priority level, four enable bits, four latched request bits and four detection bits. A single-cycle pulse on a source input latches the matching request bit. The bit stays set until software clears it.

Software reaches the bank through a plain synchronous register bus. The bus has a word address, write data, a write strobe and a combinational read-data return. Every access completes in the cycle it is presented, so the bus has no valid/ready handshake and no back-pressure. To clear a request, software writes the new request value into the request field. In the same write it sets the matching bit of the detection field, which acts as a per-bit write mask. The detection field is never stored from the bus. It always reflects enable AND request.

For each group the bank drives its level field and a pending flag to an external arbiter. The pending flag is the OR of the group's detection bits. Arbitration between groups is done outside this block.

Top module: `irq_group_bank`

## Requirements
- R1: After reset, every register reads 0x0000, and every level output and pending output is 0.
- R2: Register word layout: bit 15 always reads 0; bits 14:12 are the level; bits 11:8 are enable bits 3..0; bits 7:4 are request bits 3..0; bits 3:0 are detection bits 3..0. Word address k (k = 0..17) selects group index k.
- R3: Every write to a group's address loads its level and enable fields from the write data.
- R4: Detection bit n equals enable bit n AND request bit n. A read in the cycle after a write shows the values that result from that write. Detection bits written on the bus are not stored.
- R5: When write-data bit n (n = 0..3) is 1, request bit n takes the value of write-data bit 4+n.
- R6: When write-data bit n is 0, request bit n keeps its value, whatever was written to bit 4+n.
- R7: A one-cycle high on source input (group*4 + n) sets that group's request bit n from the next cycle. The bit stays set until software clears it.
- R8: A source pulse in the same cycle as a write that clears the same request bit wins, and the bit stays set.
- R9: grp_pending[g] is the OR of group g's detection bits. grp_level[g*3 +: 3] equals group g's level field.
- R10: Addresses 18 and above read 0x0000. Writes to them change no group.
- R11: A write to one group leaves every other group's register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_src | input | NUM_GROUPS*4 (72) | Source pulses, bit group*4+n |
| grp_level | output | NUM_GROUPS*3 (54) | Level field of each group |
| grp_pending | output | NUM_GROUPS (18) | Any enabled request pending, per group |

## Verification
The embedded properties assume the write strobe and the source inputs are known (not X) at each rising edge. They also assume a source pulse and a write are both sampled at the same edge. The bench meets this by changing every input only on the falling edge and holding it for a whole cycle.

The stimulus deliberately places a source pulse and a clearing write on the same edge, so the collision rule is exercised under the same sampling the properties use. Unmapped writes use full-ones data, so any decode leak shows up as a changed group.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int SRC_N   = 4;
  localparam int LVL_W   = 3;
  localparam int WORD_W  = 16;
  localparam int DET_LSB = 0;
  localparam int REQ_LSB = DET_LSB + SRC_N;
  localparam int EN_LSB  = REQ_LSB + SRC_N;
  localparam int LVL_LSB = EN_LSB + SRC_N;
  localparam int RSV_BIT = LVL_LSB + LVL_W;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [SRC_N-1:0] en;
    logic [SRC_N-1:0] req;
  } grp_state_t;

  function automatic logic [WORD_W-1:0] pack_word(grp_state_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LVL_LSB +: LVL_W] = s.lvl;
    w[EN_LSB  +: SRC_N] = s.en;
    w[REQ_LSB +: SRC_N] = s.req;
    w[DET_LSB +: SRC_N] = s.en & s.req;
    return w;
  endfunction
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 18,
  parameter int ADDR_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  output logic [NUM_GROUPS-1:0] sel,
  output logic [NUM_GROUPS-1:0] wr_sel,
  output logic                  hit
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cmp
    assign sel[g]    = (addr == ADDR_W'(g));
    assign wr_sel[g] = sel[g] & we;
  end
  assign hit = |sel;

  // R10 / R11: at most one group is written per cycle, and never on a miss
  assert_one_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  assert_miss_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (wr_sel == '0));
endmodule

// File: rtl/irq_group_reg.sv
module irq_group_reg
  import irq_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SRC_N-1:0]  src,
  output logic [WORD_W-1:0] word,
  output logic [LVL_W-1:0]  level,
  output logic              pending
);
  grp_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_sel) begin
      st_d.lvl = wdata[LVL_LSB +: LVL_W];
      st_d.en  = wdata[EN_LSB  +: SRC_N];
    end
    for (int n = 0; n < SRC_N; n++) begin
      if (src[n])
        st_d.req[n] = 1'b1;
      else if (wr_sel && wdata[DET_LSB + n])
        st_d.req[n] = wdata[REQ_LSB + n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign word    = pack_word(st_q);
  assign level   = st_q.lvl;
  assign pending = |word[DET_LSB +: SRC_N];

  assert_fields_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (level == $past(wdata[LVL_LSB +: LVL_W])) &&
               (word[EN_LSB +: SRC_N] == $past(wdata[EN_LSB +: SRC_N])));

  for (genvar n = 0; n < SRC_N; n++) begin : g_chk
    assert_src_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      src[n] |=> word[REQ_LSB + n]);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (word[REQ_LSB + n] && !(wr_sel && wdata[DET_LSB + n])) |=> word[REQ_LSB + n]);
    assert_masked_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && wdata[DET_LSB + n] && !src[n]) |=>
        (word[REQ_LSB + n] == $past(wdata[REQ_LSB + n])));
    assert_unmasked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && !wdata[DET_LSB + n] && !src[n]) |=> $stable(word[REQ_LSB + n]));
  end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_GROUPS-1:0]        sel,
  input  logic                         hit,
  input  logic [NUM_GROUPS*WORD_W-1:0] words,
  output logic [WORD_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      rdata = rdata | (words[g*WORD_W +: WORD_W] & {WORD_W{sel[g]}});
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == '0));
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[RSV_BIT]);
endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 18,
  parameter int ADDR_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic [NUM_GROUPS*SRC_N-1:0] irq_src,
  output logic [NUM_GROUPS*LVL_W-1:0] grp_level,
  output logic [NUM_GROUPS-1:0]       grp_pending
);
  localparam int WORDS_W = NUM_GROUPS * WORD_W;

  logic [NUM_GROUPS-1:0] sel, wr_sel;
  logic                  hit;
  logic [WORDS_W-1:0]    words;

  irq_addr_dec #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .sel(sel), .wr_sel(wr_sel), .hit(hit));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_group_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel[g]), .wdata(bus_wdata),
      .src(irq_src[g*SRC_N +: SRC_N]),
      .word(words[g*WORD_W +: WORD_W]),
      .level(grp_level[g*LVL_W +: LVL_W]),
      .pending(grp_pending[g]));

    // R9: pending follows any set detection bit of the group
    assert_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grp_pending[g] == (words[g*WORD_W + DET_LSB +: SRC_N] != '0));
  end

  irq_rd_mux #(.NUM_GROUPS(NUM_GROUPS)) u_mux (
    .clk(clk), .rst_n(rst_n), .sel(sel), .hit(hit),
    .words(words), .rdata(bus_rdata));
endmodule

// File: tb/irq_group_bank_tb.sv
module irq_group_bank_tb;
  localparam int NG = 18;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [15:0]   bus_rdata;
  logic [NG*4-1:0] irq_src = '0;
  logic [NG*3-1:0] grp_level;
  logic [NG-1:0]   grp_pending;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [2:0] m_lvl [NG];
  logic [3:0] m_en  [NG];
  logic [3:0] m_req [NG];

  always #4 clk = ~clk;

  irq_group_bank #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .grp_level(grp_level), .grp_pending(grp_pending));

  function automatic logic [15:0] exp_word(int g);
    return {1'b0, m_lvl[g], m_en[g], m_req[g], m_en[g] & m_req[g]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  // model update per R3, R5, R6, R10
  task automatic model_write(input int a, input logic [15:0] d, input logic [3:0] srcs);
    if (a < NG) begin
      m_lvl[a] = d[14:12];
      m_en[a]  = d[11:8];
      for (int n = 0; n < 4; n++)
        if (srcs[n]) m_req[a][n] = 1'b1;
        else if (d[n]) m_req[a][n] = d[4+n];
    end
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d, 4'b0);
  endtask

  task automatic pulse_src(input int g, input int n);
    @(negedge clk);
    irq_src[g*4+n] = 1'b1;
    @(negedge clk);
    irq_src = '0;
    m_req[g][n] = 1'b1;
  endtask

  task automatic check_group(input int g, input string tag);
    logic [15:0] d;
    bus_read(g, d);
    chk(tag, d, exp_word(g));
    chk({tag, " R9 level"}, 16'(grp_level[g*3 +: 3]), 16'(m_lvl[g]));
    chk({tag, " R9 pending"}, 16'(grp_pending[g]), 16'(|(m_en[g] & m_req[g])));
  endtask

  task automatic check_all(input string tag);
    for (int g = 0; g < NG; g++) check_group(g, tag);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 32; a++) begin
      bus_read(a, d);
      chk("R1 reset read", d, 16'h0);
    end
    chk("R1 levels", 16'(grp_level != '0), 16'h0);
    chk("R1 pending", 16'(grp_pending), 16'h0);
  endtask

  task automatic t_layout;
    bus_write(0, 16'hFFFF);
    check_group(0, "R2 R3 R4 full write");
    check_all("R11 after group0 write");
  endtask

  task automatic t_clear;
    bus_write(0, 16'h7F01);
    check_group(0, "R5 clear req0");
    bus_write(0, 16'h7F0A);
    check_group(0, "R5 clear req1 req3");
    bus_write(0, 16'h7FF0);
    check_group(0, "R6 unmasked ones");
    bus_write(0, 16'h7F02);
    check_group(0, "R5 R6 mixed");
  endtask

  task automatic t_enable;
    bus_write(0, 16'h3000);
    check_group(0, "R4 enable off");
    bus_write(0, 16'h3A00);
    check_group(0, "R4 partial enable");
  endtask

  task automatic t_source;
    bus_write(5, 16'h5F00);
    check_group(5, "R7 before pulse");
    pulse_src(5, 2);
    check_group(5, "R7 pulse sets");
    repeat (5) @(negedge clk);
    check_group(5, "R7 sticky");
    pulse_src(17, 3);
    check_group(17, "R7 last group");
  endtask

  task automatic t_collision;
    @(negedge clk);
    bus_addr = AW'(5); bus_wdata = 16'h5F04; bus_we = 1'b1;
    irq_src[5*4+2] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; irq_src = '0;
    model_write(5, 16'h5F04, 4'b0100);
    check_group(5, "R8 source wins");
    bus_write(5, 16'h5F04);
    check_group(5, "R5 cleared after collision");
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    bus_write(18, 16'hFFFF);
    bus_write(31, 16'hFFFF);
    bus_read(18, d); chk("R10 read 18", d, 16'h0);
    bus_read(31, d); chk("R10 read 31", d, 16'h0);
    check_all("R10 groups untouched");
  endtask

  task automatic t_last;
    bus_write(17, 16'h6C33);
    check_group(17, "R2 group 17");
    check_all("R11 after group17 write");
  endtask

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_lvl[g] = '0; m_en[g] = '0; m_req[g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_clear();
    t_enable();
    t_source();
    t_collision();
    t_unmapped();
    t_last();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule